// File: doc/BRIEF.md
# Dual-Port Video Memory Transfer Controller

This block models the transfer engine of a dual-port video memory. It has a random-access array of rows, each holding COLS words of WORD bits, and a one-row serial buffer that feeds, or is fed by, a serial port. A row cycle opens on the falling edge of the row strobe. At that edge the block reads its control pins and decides whether the cycle moves data between the array and the serial buffer, and which of four kinds of move it is. Later in the same row cycle, the column strobe falls to latch a column. The rising edge of the transfer output-enable then performs the move.

A full (non-split) transfer moves a whole row. It also fixes the serial port direction and places the serial pointer at the latched column. A split transfer moves only the half of the buffer that the pointer is not in. It leaves the direction alone and arms a jump: when the pointer reaches the end of its current segment, it continues at the new start column. The segment size is selectable. Each rising edge of the serial clock either presents one buffer word on the serial output or stores one serial input word, then steps the pointer.

All pins are sampled on the system clock. Each output is registered, so it reflects a pin edge one clock after the edge is sampled.

Top module: `vram_xfer_ctrl`

## Requirements
- R1: A row-strobe fall with the column strobe high and transfer output-enable low starts a transfer cycle, and xfer_busy rises one clock later. The kind is reported on xfer_kind: 0 full read (both write enables high, fn_sel 0), 1 split read (both write enables high, fn_sel 1), 2 masked write (either write enable low, fn_sel 0), 3 masked split write (either write enable low, fn_sel 1). A row-strobe fall with the column strobe low starts nothing and leaves xfer_kind unchanged.
- R2: In a full read, the output-enable rise copies the addressed row (row index taken from the low address bits at the row-strobe fall) into the serial buffer. It also sets the pointer to the column latched at the column-strobe fall and sets the port direction to output.
- R3: After a full read, sdo_en is 0 until the first serial clock rise. That rise drives sdo with the buffer word at the start column and sets sdo_en.
- R4: Each serial clock rise with no jump armed steps the pointer by one, and the pointer wraps from column COLS-1 to 0.
- R5: Masked writes load the mask from dq_in at the row-strobe fall. In a full masked write, the output-enable rise writes each bit of the buffer whose mask bit is 1 into the addressed row; bits with mask 0 keep their old value. It then sets the direction to input (sdo_en 0) and the pointer to the latched column.
- R6: In input direction, a serial clock rise stores sdi into the buffer word at the pointer.
- R7: Until the first full transfer after reset, every serial clock rise pulses ser_err for one clock and leaves the pointer and buffer unchanged. Split transfers do not end this state.
- R8: A split read copies only the buffer half that does not hold the pointer (columns below COLS/2 or at and above it). It keeps the direction and sdo_en, and arms a jump to the latched column placed in that half. The jump is taken by the serial clock rise that reads or writes the last column of the pointer's current segment.
- R9: A masked split write writes, under the mask, only the half of the buffer that does not hold the pointer into the same half of the row. It keeps the direction and arms the jump as in R8.
- R10: seg_sel selects the segment length: 0 gives COLS/2, 1 gives COLS/4, 2 gives COLS/8, 3 gives COLS/16. When seg_sel is nonzero and a split start column is the last column of a segment, start_rej pulses for one clock, no jump is armed, and the data is still copied.
- R11: After reset, xfer_busy, sdo_en, ser_err and start_rej are 0, xfer_kind is 0, sdo is 0, and the array and buffer hold zeros.
- R12: At most one transfer runs per row cycle. xfer_busy clears at the transfer or at the row-strobe rise. An output-enable rise while xfer_busy is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| xfer_oe_n | input | 1 | Transfer output-enable; its rise performs the move |
| wr_hi_n | input | 1 | Upper byte write enable, active low |
| wr_lo_n | input | 1 | Lower byte write enable, active low |
| fn_sel | input | 1 | Selects split (1) or full (0) transfer |
| addr | input | COL_W | Row index at row-strobe fall, column at column-strobe fall |
| dq_in | input | WORD | Data bus, source of the write mask |
| seg_sel | input | 2 | Serial segment length select |
| sclk | input | 1 | Serial clock |
| sdi | input | WORD | Serial input word |
| sdo | output | WORD | Serial output word |
| sdo_en | output | 1 | Serial output driven |
| xfer_kind | output | 2 | Kind of the last transfer cycle |
| xfer_busy | output | 1 | Transfer cycle open and not yet performed |
| ser_err | output | 1 | Serial access before any start address |
| start_rej | output | 1 | Split start column rejected |

## Verification
A wrong pointer, a lost armed jump or a half copied to the wrong side shows up as a wrong sdo word on the next serial clock that reaches the affected column. That can be several hundred clocks after the transfer, so every serial word is compared against an independent model of the row contents. A decode error shows one clock after the row-strobe fall on xfer_kind and xfer_busy. A bad mask or write path only surfaces after a later full read of that row is clocked out.

// File: rtl/vram_xfer_pkg.sv
package vram_xfer_pkg;

    // Cycle kind: bit 1 = array is the destination, bit 0 = half-buffer move
    typedef enum logic [1:0] {
        XK_READ         = 2'b00,
        XK_SPLIT_READ   = 2'b01,
        XK_MWRITE       = 2'b10,
        XK_SPLIT_MWRITE = 2'b11
    } xfer_kind_e;

endpackage

// File: rtl/strobe_sampler.sv
// Holds the previous clock's level of each strobe so edges can be found.
module strobe_sampler #(
    parameter int           N    = 4,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] prev
);
    logic [N-1:0] prev_d;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_comb prev_d[g] = pins[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE;
        else        prev <= prev_d;
    end
endmodule

// File: rtl/xfer_decode.sv
// Pure decode of the pin levels present at the row-strobe fall.
module xfer_decode
    import vram_xfer_pkg::*;
(
    input  logic       col_stb_n,
    input  logic       xfer_oe_n,
    input  logic       wr_hi_n,
    input  logic       wr_lo_n,
    input  logic       fn_sel,
    output logic       is_xfer,
    output xfer_kind_e kind
);
    always_comb begin
        is_xfer = col_stb_n & ~xfer_oe_n;
        kind    = xfer_kind_e'({~(wr_hi_n & wr_lo_n), fn_sel});
    end
endmodule

// File: rtl/seg_boundary.sv
// Flags a column that is the last one of its serial segment.
module seg_boundary #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] col,
    input  logic [1:0]       seg_sel,
    output logic             is_last
);
    localparam int HW = COL_W - 1;
    logic [HW-1:0] seg_mask;

    always_comb begin
        seg_mask = {HW{1'b1}} >> seg_sel;
        is_last  = (col[HW-1:0] & seg_mask) == seg_mask;
    end
endmodule

// File: rtl/vram_xfer_ctrl.sv
module vram_xfer_ctrl
    import vram_xfer_pkg::*;
#(
    parameter int COLS = 256,
    parameter int WORD = 16,
    parameter int ROWS = 4,
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_stb_n,
    input  logic             col_stb_n,
    input  logic             xfer_oe_n,
    input  logic             wr_hi_n,
    input  logic             wr_lo_n,
    input  logic             fn_sel,
    input  logic [COL_W-1:0] addr,
    input  logic [WORD-1:0]  dq_in,
    input  logic [1:0]       seg_sel,
    input  logic             sclk,
    input  logic [WORD-1:0]  sdi,
    output logic [WORD-1:0]  sdo,
    output logic             sdo_en,
    output logic [1:0]       xfer_kind,
    output logic             xfer_busy,
    output logic             ser_err,
    output logic             start_rej
);
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int HALF  = COLS / 2;
    localparam logic [COL_W-1:0] STEP = 1;

    typedef struct packed {
        logic             busy;
        xfer_kind_e       kind;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [WORD-1:0]  mask;
        logic [COL_W-1:0] ptr;
        logic             valid;
        logic             dir_out;
        logic             en;
        logic [WORD-1:0]  sdo;
        logic             pend;
        logic [COL_W-1:0] paddr;
        logic             ser_err;
        logic             rej;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [WORD-1:0] mem_d [ROWS][COLS];
    logic [WORD-1:0] mem_q [ROWS][COLS];
    logic [WORD-1:0] buf_d [COLS];
    logic [WORD-1:0] buf_q [COLS];

    // ---- strobe edges ----
    logic [3:0] pin_prev;
    logic       row_fall, row_rise, col_fall, oe_rise, sclk_rise;

    strobe_sampler #(.N(4), .IDLE(4'b0111)) u_smp (
        .clk  (clk),
        .rst_n(rst_n),
        .pins ({sclk, xfer_oe_n, col_stb_n, row_stb_n}),
        .prev (pin_prev)
    );

    assign row_fall  =  pin_prev[0] & ~row_stb_n;
    assign row_rise  = ~pin_prev[0] &  row_stb_n;
    assign col_fall  =  pin_prev[1] & ~col_stb_n;
    assign oe_rise   = ~pin_prev[2] &  xfer_oe_n;
    assign sclk_rise = ~pin_prev[3] &  sclk;

    // ---- decode ----
    logic       dec_xfer;
    xfer_kind_e dec_kind;

    xfer_decode u_dec (
        .col_stb_n(col_stb_n),
        .xfer_oe_n(xfer_oe_n),
        .wr_hi_n  (wr_hi_n),
        .wr_lo_n  (wr_lo_n),
        .fn_sel   (fn_sel),
        .is_xfer  (dec_xfer),
        .kind     (dec_kind)
    );

    // ---- segment ends ----
    logic             half_sel;
    logic [COL_W-1:0] start_col;
    logic             ptr_last, start_last;

    assign half_sel  = ~c_q.ptr[COL_W-1];
    assign start_col = {half_sel, c_q.col[COL_W-2:0]};

    seg_boundary #(.COL_W(COL_W)) u_ptr_end (
        .col(c_q.ptr), .seg_sel(seg_sel), .is_last(ptr_last)
    );
    seg_boundary #(.COL_W(COL_W)) u_start_end (
        .col(start_col), .seg_sel(seg_sel), .is_last(start_last)
    );

    logic fire;
    assign fire = c_q.busy & oe_rise;

    // ---- next state ----
    always_comb begin
        c_d         = c_q;
        c_d.ser_err = 1'b0;
        c_d.rej     = 1'b0;
        mem_d       = mem_q;
        buf_d       = buf_q;

        if (row_fall && dec_xfer) begin
            c_d.busy = 1'b1;
            c_d.kind = dec_kind;
            c_d.row  = addr[ROW_W-1:0];
            if (dec_kind[1]) c_d.mask = dq_in;
        end
        if (c_q.busy && col_fall) c_d.col = addr;
        if (c_q.busy && row_rise) c_d.busy = 1'b0;

        if (fire) begin
            c_d.busy = 1'b0;
            for (int i = 0; i < COLS; i++) begin
                if (!c_q.kind[0] || (((i >= HALF) ? 1'b1 : 1'b0) == half_sel)) begin
                    if (c_q.kind[1])
                        mem_d[c_q.row][i] = (mem_q[c_q.row][i] & ~c_q.mask)
                                          | (buf_q[i] & c_q.mask);
                    else
                        buf_d[i] = mem_q[c_q.row][i];
                end
            end
            if (!c_q.kind[0]) begin
                c_d.ptr     = c_q.col;
                c_d.dir_out = ~c_q.kind[1];
                c_d.en      = 1'b0;
                c_d.valid   = 1'b1;
                c_d.pend    = 1'b0;
            end else begin
                c_d.rej   = (seg_sel != 2'd0) && start_last;
                c_d.pend  = ~((seg_sel != 2'd0) && start_last);
                c_d.paddr = start_col;
            end
        end else if (sclk_rise) begin
            if (!c_q.valid) begin
                c_d.ser_err = 1'b1;
            end else begin
                if (c_q.dir_out) begin
                    c_d.sdo = buf_q[c_q.ptr];
                    c_d.en  = 1'b1;
                end else begin
                    buf_d[c_q.ptr] = sdi;
                end
                if (c_q.pend && ptr_last) begin
                    c_d.ptr  = c_q.paddr;
                    c_d.pend = 1'b0;
                end else begin
                    c_d.ptr = c_q.ptr + STEP;
                end
            end
        end
    end

    // ---- registers ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
            for (int r = 0; r < ROWS; r++)
                for (int i = 0; i < COLS; i++)
                    mem_q[r][i] <= '0;
            for (int i = 0; i < COLS; i++) buf_q[i] <= '0;
        end else begin
            c_q   <= c_d;
            mem_q <= mem_d;
            buf_q <= buf_d;
        end
    end

    logic [COL_W-1:0] ptr_now;
    assign ptr_now   = c_q.ptr;
    assign sdo       = c_q.sdo;
    assign sdo_en    = c_q.en;
    assign xfer_kind = c_q.kind;
    assign xfer_busy = c_q.busy;
    assign ser_err   = c_q.ser_err;
    assign start_rej = c_q.rej;
endmodule

// File: rtl/vram_xfer_chk.sv
module vram_xfer_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             row_stb_n,
    input logic             col_stb_n,
    input logic             xfer_oe_n,
    input logic [1:0]       seg_sel,
    input logic [1:0]       xfer_kind,
    input logic             xfer_busy,
    input logic             sdo_en,
    input logic             ser_err,
    input logic             start_rej,
    input logic [COL_W-1:0] ptr_now,
    input logic             fire,
    input logic             sclk_rise
);
    p_busy_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |-> $past(!row_stb_n && col_stb_n && !xfer_oe_n));

    p_kind_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(xfer_kind) |-> $rose(xfer_busy));

    p_out_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en) |-> $past(sclk_rise));

    p_ptr_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_now) |-> $past(fire || sclk_rise));

    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_err |-> $stable(ptr_now) && !sdo_en);

    p_rej_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_rej |-> $past(seg_sel != 2'd0) && xfer_kind[0]);

    p_busy_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_busy) |-> $past(fire || row_stb_n));
endmodule

bind vram_xfer_ctrl vram_xfer_chk #(.COL_W(COL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_stb_n(row_stb_n),
    .col_stb_n(col_stb_n),
    .xfer_oe_n(xfer_oe_n),
    .seg_sel  (seg_sel),
    .xfer_kind(xfer_kind),
    .xfer_busy(xfer_busy),
    .sdo_en   (sdo_en),
    .ser_err  (ser_err),
    .start_rej(start_rej),
    .ptr_now  (ptr_now),
    .fire     (fire),
    .sclk_rise(sclk_rise)
);

// File: tb/vram_xfer_ctrl_test.sv
module vram_xfer_ctrl_test;
    localparam int COLS = 256, WORD = 16, ROWS = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, row_stb_n, col_stb_n, xfer_oe_n, wr_hi_n, wr_lo_n, fn_sel, sclk;
    logic [7:0]  addr;
    logic [15:0] dq_in, sdi, sdo;
    logic [1:0]  seg_sel, xfer_kind;
    logic sdo_en, xfer_busy, ser_err, start_rej;

    vram_xfer_ctrl #(.COLS(COLS), .WORD(WORD), .ROWS(ROWS)) uut (.*);

    int total = 0, bad = 0;

    // bench reference state
    logic [15:0] mm [ROWS][COLS];
    logic [15:0] sm [COLS];
    logic [7:0]  pm, pam;
    logic [15:0] so_m;
    bit vm, dm, em, pendm;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit seg_last_m(logic [7:0] c, logic [1:0] s);
        int len = 128 >> s;
        return (int'(c) % len) == len - 1;
    endfunction

    task automatic sclk_pulse(string tag);
        bit e_err = !vm;
        if (vm) begin
            if (dm) begin so_m = sm[pm]; em = 1; end
            else sm[pm] = sdi;
            if (pendm && seg_last_m(pm, seg_sel)) begin pm = pam; pendm = 0; end
            else pm = pm + 8'd1;
        end
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        chk(tag, "ser_err", ser_err, e_err);
        chk(tag, "sdo_en", sdo_en, em);
        if (em) chk(tag, "sdo", sdo, so_m);
        @(negedge clk);
    endtask

    task automatic xfer(logic [1:0] k, int row, int col, logic [15:0] m, string tag);
        bit h, rej;
        col_stb_n = 1; xfer_oe_n = 0;
        wr_hi_n = ~k[1]; wr_lo_n = ~k[1]; fn_sel = k[0];
        addr = 8'(row); dq_in = m;
        @(negedge clk); row_stb_n = 0;
        @(negedge clk);
        chk("R1", "busy", xfer_busy, 1);
        chk("R1", "kind", xfer_kind, k);
        col_stb_n = 0; addr = 8'(col);
        @(negedge clk); xfer_oe_n = 1;
        // reference effect of the move
        h = ~pm[7]; rej = 0;
        for (int i = 0; i < COLS; i++)
            if (!k[0] || ((i >= 128) == h)) begin
                if (k[1]) mm[row][i] = (mm[row][i] & ~m) | (sm[i] & m);
                else      sm[i] = mm[row][i];
            end
        if (!k[0]) begin
            pm = 8'(col); dm = ~k[1]; em = 0; vm = 1; pendm = 0;
        end else begin
            pam = {h, 7'(col)};
            rej = (seg_sel != 0) && seg_last_m(pam, seg_sel);
            pendm = !rej;
        end
        @(negedge clk);
        chk("R10", "start_rej", start_rej, rej);
        chk("R12", "busy after move", xfer_busy, 0);
        chk(tag, "sdo_en after move", sdo_en, em);
        row_stb_n = 1; col_stb_n = 1; wr_hi_n = 1; wr_lo_n = 1;
        @(negedge clk);
    endtask

    task automatic plain_cycle();
        logic [1:0] k0 = xfer_kind;
        col_stb_n = 0; xfer_oe_n = 0;
        @(negedge clk); row_stb_n = 0;
        @(negedge clk);
        chk("R1", "busy on non-transfer", xfer_busy, 0);
        xfer_oe_n = 1;
        @(negedge clk);
        chk("R12", "busy after stray oe", xfer_busy, 0);
        chk("R1", "kind unchanged", xfer_kind, k0);
        row_stb_n = 1; col_stb_n = 1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] m;
        void'($urandom(32'h1234_5eed));
        rst_n = 0; row_stb_n = 1; col_stb_n = 1; xfer_oe_n = 1;
        wr_hi_n = 1; wr_lo_n = 1; fn_sel = 0; sclk = 0;
        addr = 0; dq_in = 0; sdi = 0; seg_sel = 0;
        for (int r = 0; r < ROWS; r++) for (int i = 0; i < COLS; i++) mm[r][i] = 0;
        for (int i = 0; i < COLS; i++) sm[i] = 0;
        pm = 0; pam = 0; so_m = 0; vm = 0; dm = 0; em = 0; pendm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11", "busy", xfer_busy, 0);
        chk("R11", "sdo_en", sdo_en, 0);
        chk("R11", "ser_err", ser_err, 0);
        chk("R11", "start_rej", start_rej, 0);
        chk("R11", "kind", xfer_kind, 0);
        chk("R11", "sdo", sdo, 0);

        // serial access before any start address
        sclk_pulse("R7");
        xfer(2'd1, 1, 5, 0, "R7");
        sclk_pulse("R7");

        // fill rows through the serial input path
        xfer(2'd2, 0, 0, 16'hFFFF, "R5");
        for (int i = 0; i < COLS; i++) begin sdi = 16'($urandom); sclk_pulse("R6"); end
        xfer(2'd2, 1, 0, 16'hFFFF, "R5");
        xfer(2'd2, 2, 0, 16'hFFFF, "R5");
        for (int i = 0; i < COLS; i++) begin sdi = 16'($urandom); sclk_pulse("R6"); end
        xfer(2'd2, 3, 0, 16'hFFFF, "R5");
        m = 16'($urandom);
        xfer(2'd2, 2, 0, m, "R5");

        // full read near the top, wraps past the last column
        xfer(2'd0, 2, 250, 0, "R3");
        for (int i = 0; i < 10; i++) sclk_pulse("R4");
        plain_cycle();
        sclk_pulse("R12");

        // split read with default segments: jump at column 127
        xfer(2'd1, 3, 37, 0, "R8");
        for (int i = 0; i < 125; i++) sclk_pulse("R8");

        // masked split write with 32-word segments
        seg_sel = 2'd2;
        xfer(2'd3, 0, 10, 16'($urandom), "R9");
        for (int i = 0; i < 30; i++) sclk_pulse("R10");
        seg_sel = 2'd0;
        xfer(2'd0, 0, 0, 0, "R9");
        for (int i = 0; i < 8; i++) sclk_pulse("R9");
        xfer(2'd0, 0, 128, 0, "R9");
        for (int i = 0; i < 3; i++) sclk_pulse("R9");

        // boundary start column is refused
        seg_sel = 2'd1;
        xfer(2'd1, 1, 63, 0, "R10");
        for (int i = 0; i < 70; i++) sclk_pulse("R10");

        // full reads at random places
        seg_sel = 2'd0;
        for (int n = 0; n < 6; n++) begin
            xfer(2'd0, int'($urandom % ROWS), int'($urandom % COLS), 0, "R2");
            for (int i = 0; i < 4; i++) sclk_pulse("R2");
        end

        // mixed random traffic
        for (int n = 0; n < 24; n++) begin
            logic [1:0] k = 2'($urandom);
            seg_sel = 2'($urandom);
            xfer(k, int'($urandom % ROWS), int'($urandom % COLS), 16'($urandom),
                 k[0] ? "R8" : "R2");
            for (int i = 0; i < int'($urandom % 90); i++) begin
                sdi = 16'($urandom);
                sclk_pulse(dm ? "R4" : "R6");
            end
        end
        finish_run();
    end
endmodule